// File: doc/BRIEF.md
# Light-Load Sleep Controller

This block sits beside the synchronous-rectifier gate logic and decides, once per switching cycle, whether that logic runs normally or is parked in a low-power sleep mode. Each cycle an upstream measurement unit reports how long the internal timing ramp took to discharge, as a tick count on `dis_ticks`, and marks it with a one-clock `cyc_done` strobe. A short discharge time means a light load. A run of short cycles puts the block to sleep. A longer run of long cycles wakes it. The wake threshold sits above the sleep threshold, so a load near the boundary does not make the block toggle between modes.

Sleep is also entered in two other ways. The first is a timeout when the gate-activity indication stays low for a programmable number of clocks. The second is any of three force requests from the protection logic: a switching-period fault, an open sense pin and a shorted feedback-divider pin. While the block is asleep, its registered gate output is held low whatever the gate request is.

Top module: `lls_sleep_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, `sleep` and `gate_out` are 0. Both qualifying-cycle counters and the idle timer start from zero.
- R2: In run mode, a strobe with `dis_ticks < thr_enter` is a short cycle. Sleep is entered on the clock edge of the 4th consecutive short strobe (strictly more than ENTER_CNT=3), so `sleep` reads 1 right after that edge. Three short strobes alone do not enter sleep.
- R3: In run mode, a strobe with `dis_ticks >= thr_enter` (equality included) clears the short-cycle count to zero.
- R4: In sleep mode, a strobe with `dis_ticks > thr_exit` is a long cycle. Sleep is left on the edge of the 8th consecutive long strobe (strictly more than EXIT_CNT=7). `thr_exit` must exceed `thr_enter`.
- R5: In sleep mode, a strobe with `dis_ticks <= thr_exit` (equality included) clears the long-cycle count to zero.
- R6: In run mode, IDLE_TICKS consecutive clocks with `gate_act` low put the block to sleep on the last of those edges. A clock with `gate_act` high restarts the count.
- R7: Any of `fault_period`, `fault_sense_open` or `fault_fb_short` high at a clock edge makes `sleep` 1 after that edge. Long strobes seen while a request is held do not count towards waking.
- R8: A force request wins over a wake that falls in the same clock. The block stays asleep and the long-cycle count restarts from zero.
- R9: `gate_out` is a register. It equals `gate_req` from the previous edge while the block is awake, and it is 0 in every cycle where `sleep` is 1.
- R10: `dis_ticks` is ignored in clocks without `cyc_done`. The qualifying counts neither advance nor clear in those clocks.
- R11: Every mode change clears both qualifying-cycle counts, so counts gathered before sleep do not carry over after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_done | input | 1 | One-clock strobe: `dis_ticks` holds this cycle's measurement |
| dis_ticks | input | TW | Ramp discharge time of the finished cycle, in ticks |
| thr_enter | input | TW | Sleep threshold in ticks |
| thr_exit | input | TW | Wake threshold in ticks, above `thr_enter` |
| gate_act | input | 1 | Gate activity seen in this clock |
| gate_req | input | 1 | Gate drive request from the rectifier timing logic |
| fault_period | input | 1 | Force sleep: switching-period fault |
| fault_sense_open | input | 1 | Force sleep: winding-sense pin open |
| fault_fb_short | input | 1 | Force sleep: feedback-divider pin shorted |
| sleep | output | 1 | Registered sleep flag |
| gate_out | output | 1 | Registered gate drive, low while asleep |

## Verification
The assertions assume that `thr_exit` stays strictly above `thr_enter` and that every cause of a mode change is seen on the ports one clock before the flag moves. The stimulus therefore holds the thresholds at 100 and 120 ticks and drives every input half a clock away from the sampling edge. Strobes are separated by idle clocks with `gate_act` high, so the idle timeout only fires in the test written for it. Each measured value is chosen clearly on one side of a threshold, or exactly on it when the equality case is the point of the check.

// File: rtl/lls_pkg.sv
package lls_pkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } lls_mode_e;

  // Number of bits needed to hold the values 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/lls_classify.sv
module lls_classify #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] dis_ticks,
  input  logic [TW-1:0] thr_enter,
  input  logic [TW-1:0] thr_exit,
  output logic          is_short,
  output logic          is_long
);
  // strict compares on both sides: the equal value qualifies for neither
  always_comb begin
    is_short = (dis_ticks < thr_enter);
    is_long  = (dis_ticks > thr_exit);
  end
endmodule

// File: rtl/lls_streak.sv
module lls_streak #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic strobe,
  input  logic qual,
  output logic hit
);
  localparam int CW = lls_pkg::cnt_width(LIMIT);

  logic [CW-1:0] cnt;

  // hit when one more qualifying cycle arrives after LIMIT already counted
  assign hit = en & strobe & qual & (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && strobe) begin
      if (!qual || hit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lls_idle_timer.sv
module lls_idle_timer #(
  parameter int IDLE_TICKS = 15000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic act,
  output logic expired
);
  localparam int CW = lls_pkg::cnt_width(IDLE_TICKS);

  logic [CW-1:0] cnt;

  assign expired = en & ~act & (cnt == CW'(IDLE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || act || expired) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lls_mode_fsm.sv
module lls_mode_fsm #(
  parameter int NFLT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] force_req,
  input  logic            enter_hit,
  input  logic            idle_exp,
  input  logic            exit_hit,
  input  logic            gate_req,
  output logic            run_mode,
  output logic            cnt_clr,
  output logic            sleep,
  output logic            gate_out
);
  import lls_pkg::*;

  lls_mode_e mode, mode_nxt;
  logic      forced;

  assign forced = |force_req;

  always_comb begin
    mode_nxt = mode;
    if (forced)
      mode_nxt = MODE_SLEEP;                 // force beats any wake
    else if (mode == MODE_RUN && (enter_hit || idle_exp))
      mode_nxt = MODE_SLEEP;
    else if (mode == MODE_SLEEP && exit_hit)
      mode_nxt = MODE_RUN;
  end

  assign run_mode = (mode == MODE_RUN);
  assign cnt_clr  = forced | (mode_nxt != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_RUN;
      gate_out <= 1'b0;
    end else begin
      mode     <= mode_nxt;
      gate_out <= gate_req & (mode_nxt == MODE_RUN);
    end
  end

  assign sleep = (mode == MODE_SLEEP);
endmodule

// File: rtl/lls_sleep_ctrl.sv
module lls_sleep_ctrl #(
  parameter int TW         = 12,
  parameter int ENTER_CNT  = 3,
  parameter int EXIT_CNT   = 7,
  parameter int IDLE_TICKS = 15000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_done,
  input  logic [TW-1:0] dis_ticks,
  input  logic [TW-1:0] thr_enter,
  input  logic [TW-1:0] thr_exit,
  input  logic          gate_act,
  input  logic          gate_req,
  input  logic          fault_period,
  input  logic          fault_sense_open,
  input  logic          fault_fb_short,
  output logic          sleep,
  output logic          gate_out
);
  localparam int NFLT = 3;
  localparam int NDIR = 2;   // 0: towards sleep, 1: towards run

  logic            is_short, is_long;
  logic            run_mode, cnt_clr, idle_exp;
  logic [NDIR-1:0] dir_en, dir_qual, dir_hit;

  lls_classify #(.TW(TW)) u_cls (
    .dis_ticks (dis_ticks),
    .thr_enter (thr_enter),
    .thr_exit  (thr_exit),
    .is_short  (is_short),
    .is_long   (is_long)
  );

  assign dir_en   = {~run_mode, run_mode};
  assign dir_qual = {is_long, is_short};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int LIM = (d == 0) ? ENTER_CNT : EXIT_CNT;
    lls_streak #(.LIMIT(LIM)) u_streak (
      .clk    (clk),
      .rst    (rst),
      .clr    (cnt_clr),
      .en     (dir_en[d]),
      .strobe (cyc_done),
      .qual   (dir_qual[d]),
      .hit    (dir_hit[d])
    );
  end

  lls_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .en      (run_mode),
    .act     (gate_act),
    .expired (idle_exp)
  );

  lls_mode_fsm #(.NFLT(NFLT)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .force_req ({fault_fb_short, fault_sense_open, fault_period}),
    .enter_hit (dir_hit[0]),
    .idle_exp  (idle_exp),
    .exit_hit  (dir_hit[1]),
    .gate_req  (gate_req),
    .run_mode  (run_mode),
    .cnt_clr   (cnt_clr),
    .sleep     (sleep),
    .gate_out  (gate_out)
  );
endmodule

// File: rtl/lls_sleep_ctrl_chk.sv
module lls_sleep_ctrl_chk #(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_done,
  input logic [TW-1:0] dis_ticks,
  input logic [TW-1:0] thr_enter,
  input logic [TW-1:0] thr_exit,
  input logic          gate_act,
  input logic          gate_req,
  input logic [2:0]    faults,
  input logic          sleep,
  input logic          gate_out
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!sleep && !gate_out));

  assert_enter_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> $past((|faults) || !gate_act ||
                           (cyc_done && dis_ticks < thr_enter)));

  assert_band_order_R4: assert property (@(posedge clk) disable iff (rst)
    thr_exit > thr_enter);

  assert_wake_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> $past(cyc_done && dis_ticks > thr_exit));

  assert_force_sleep_R7: assert property (@(posedge clk) disable iff (rst)
    (|faults) |=> sleep);

  assert_no_wake_forced_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> $past(faults == 3'b000));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !gate_out);

  assert_gate_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !$past(rst)) |-> (gate_out == $past(gate_req)));

  assert_strobe_only_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleep) || ($rose(sleep) && $past(gate_act) && $past(faults == 3'b000)))
      |-> $past(cyc_done));
endmodule

bind lls_sleep_ctrl lls_sleep_ctrl_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_done  (cyc_done),
  .dis_ticks (dis_ticks),
  .thr_enter (thr_enter),
  .thr_exit  (thr_exit),
  .gate_act  (gate_act),
  .gate_req  (gate_req),
  .faults    ({fault_fb_short, fault_sense_open, fault_period}),
  .sleep     (sleep),
  .gate_out  (gate_out)
);

// File: tb/lls_sleep_ctrl_test.sv
module lls_sleep_ctrl_test;
  localparam int TW   = 12;
  localparam int IDLE = 15000;
  localparam int SHORT_T = 50;
  localparam int LONG_T  = 130;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc_done = 1'b0;
  logic [TW-1:0] dis_ticks = '0;
  logic [TW-1:0] thr_enter = TW'(100);
  logic [TW-1:0] thr_exit  = TW'(120);
  logic          gate_act = 1'b1;
  logic          gate_req = 1'b0;
  logic [2:0]    flt = 3'b000;
  logic          sleep, gate_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic  s;
    logic  g;
    bit    chk;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lls_sleep_ctrl #(.TW(TW), .ENTER_CNT(3), .EXIT_CNT(7), .IDLE_TICKS(IDLE)) uut (
    .clk              (clk),
    .rst              (rst),
    .cyc_done         (cyc_done),
    .dis_ticks        (dis_ticks),
    .thr_enter        (thr_enter),
    .thr_exit         (thr_exit),
    .gate_act         (gate_act),
    .gate_req         (gate_req),
    .fault_period     (flt[0]),
    .fault_sense_open (flt[1]),
    .fault_fb_short   (flt[2]),
    .sleep            (sleep),
    .gate_out         (gate_out)
  );

  // monitor: pops the expectation pushed before this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          n_chk++;
          if (sleep !== e.s || gate_out !== e.g) begin
            n_fail++;
            $display("FAIL %s: sleep=%0b gate_out=%0b expected sleep=%0b gate_out=%0b",
                     e.tag, sleep, gate_out, e.s, e.g);
          end
        end
      end
    end
  end

  task automatic cyc(input bit r, input bit cd, input int t, input bit ga,
                     input bit [2:0] f, input bit gr, input bit es,
                     input bit chk, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; cyc_done = cd; dis_ticks = TW'(t); gate_act = ga;
    flt = f; gate_req = gr;
    e.s = r ? 1'b0 : es;
    e.g = r ? 1'b0 : (gr & ~es);
    e.chk = chk;
    e.tag = tag;
    q.push_back(e);
  endtask

  // one measured cycle followed by a quiet clock
  task automatic strobe(input int t, input bit es, input bit chk, input string tag);
    cyc(0, 1, t, 1, 3'b000, 0, es, chk, tag);
    cyc(0, 0, 0, 1, 3'b000, 0, es, 0, "");
  endtask

  task automatic wake(input string tag);
    for (int i = 0; i < 7; i++) strobe(LONG_T, 1, 1, tag);
    strobe(LONG_T, 0, 1, tag);
  endtask

  initial begin
    // R1: reset state, gate request ignored during reset
    cyc(1, 0, 0, 1, 3'b000, 1, 0, 1, "R1 in reset");
    cyc(1, 0, 0, 1, 3'b000, 1, 0, 1, "R1 in reset");
    cyc(0, 0, 0, 1, 3'b000, 0, 0, 1, "R1 after reset");

    // R9: gate follows request while awake
    cyc(0, 0, 0, 1, 3'b000, 1, 0, 1, "R9 gate high awake");
    cyc(0, 0, 0, 1, 3'b000, 0, 0, 1, "R9 gate low awake");

    // R2: three short cycles stay awake, fourth enters; gate blocked (R9)
    for (int i = 0; i < 3; i++) strobe(SHORT_T, 0, 1, "R2 short below count");
    cyc(0, 1, SHORT_T, 1, 3'b000, 1, 1, 1, "R2 fourth short enters / R9 gate off");
    cyc(0, 0, 0, 1, 3'b000, 1, 1, 1, "R9 gate held off asleep");

    // R4: seven long cycles stay asleep, eighth wakes
    wake("R4 wake on eighth long");

    // R3: equal value clears short count
    for (int i = 0; i < 3; i++) strobe(SHORT_T, 0, 1, "R3 short");
    strobe(100, 0, 1, "R3 equal value not short");
    for (int i = 0; i < 3; i++) strobe(SHORT_T, 0, 1, "R3 count restarted");
    strobe(SHORT_T, 1, 1, "R3 fourth after restart enters");

    // R5: equal value clears long count
    for (int i = 0; i < 7; i++) strobe(LONG_T, 1, 1, "R5 long");
    strobe(120, 1, 1, "R5 equal value not long");
    for (int i = 0; i < 7; i++) strobe(LONG_T, 1, 1, "R5 count restarted");
    strobe(LONG_T, 0, 1, "R5 eighth after restart wakes");

    // R10: no strobe, values ignored, count kept
    for (int i = 0; i < 3; i++) strobe(SHORT_T, 0, 1, "R10 short");
    for (int i = 0; i < 5; i++) cyc(0, 0, 10, 1, 3'b000, 0, 0, 1, "R10 unstrobed ignored");
    for (int i = 0; i < 3; i++) cyc(0, 0, 500, 1, 3'b000, 0, 0, 1, "R10 unstrobed no clear");
    strobe(SHORT_T, 1, 1, "R10 count kept, fourth enters");
    wake("R10 wake");

    // R6: idle timeout with restart
    for (int i = 0; i < IDLE - 1; i++)
      cyc(0, 0, 0, 0, 3'b000, 0, 0, (i == IDLE - 2), "R6 idle one short of limit");
    cyc(0, 0, 0, 1, 3'b000, 0, 0, 1, "R6 activity restarts timer");
    for (int i = 0; i < IDLE - 1; i++)
      cyc(0, 0, 0, 0, 3'b000, 0, 0, (i == IDLE - 2), "R6 restarted, not yet");
    cyc(0, 0, 0, 0, 3'b000, 0, 1, 1, "R6 idle limit enters");
    cyc(0, 0, 0, 1, 3'b000, 0, 1, 1, "R6 stays asleep");
    wake("R6 wake");

    // R7: each force source
    for (int b = 0; b < 3; b++) begin
      cyc(0, 0, 0, 1, 3'(1 << b), 1, 1, 1, "R7 force enters");
      cyc(0, 0, 0, 1, 3'b000, 0, 1, 1, "R7 stays asleep");
      wake("R7 wake after force");
    end
    // R7: long cycles during held request do not count
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, LONG_T, 1, 3'b100, 0, 1, 1, "R7 held force blocks wake");
      cyc(0, 0, 0, 1, 3'b100, 0, 1, 0, "");
    end
    wake("R7 wake needs full count after release");

    // R8: force in same clock as the waking strobe
    cyc(0, 0, 0, 1, 3'b001, 0, 1, 1, "R8 enter by force");
    for (int i = 0; i < 7; i++) strobe(LONG_T, 1, 1, "R8 long");
    cyc(0, 1, LONG_T, 1, 3'b010, 0, 1, 1, "R8 force beats wake");
    cyc(0, 0, 0, 1, 3'b000, 0, 1, 0, "");
    strobe(LONG_T, 1, 1, "R8 count restarted");
    for (int i = 0; i < 6; i++) strobe(LONG_T, 1, 1, "R8 long");
    strobe(LONG_T, 0, 1, "R8 wake after full count");

    // R11: counts do not carry across a mode change
    for (int i = 0; i < 3; i++) strobe(SHORT_T, 0, 1, "R11 short");
    cyc(0, 0, 0, 1, 3'b001, 0, 1, 1, "R11 forced sleep");
    wake("R11 wake");
    strobe(SHORT_T, 0, 1, "R11 old short count cleared");
    for (int i = 0; i < 2; i++) strobe(SHORT_T, 0, 1, "R11 short");
    strobe(SHORT_T, 1, 1, "R11 fourth new short enters");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule